// File: doc/BRIEF.md
# Descriptor-Driven Transfer Address Sequencer

This block is the address and count engine of a small data mover. A descriptor of a mode byte, a source address, a destination address, a 16-bit transfer count and an 8-bit area length is loaded in one cycle while the block is idle. A start pulse then sets it moving data one unit at a time. Each unit is a single read beat from the source address followed by a single write beat to the destination address. The write carries the data returned by the read.

Each side steps its address on its own: it stays fixed, counts up or counts down. The step is one for byte units and two for word units. Normal mode moves a counted number of units and stops. Repeat mode wraps one side, the area side, back to its start address after every `len` units and runs until told to stop. Block mode moves `len` units per start pulse. It then rewinds the area side and counts down a block counter, holding busy between blocks.

Both bus channels use valid/ready. A valid beat keeps its address, size and data unchanged until ready is seen high at a clock edge. The bus side may hold ready low for any number of cycles. The read data is taken in the cycle the read handshake completes.

Top module: `xfer_seq`

## Requirements
- R1: The mode byte fields are: bits 7:6 source stepping, bits 5:4 destination stepping, bits 3:2 transfer mode, bit 1 area side, bit 0 unit size (1 = 16-bit word, 0 = byte). The block accepts `cfg_load` only while idle (busy low), and that load clears `done` and `err`.
- R2: A stepping field of 00 or 01 keeps that address fixed, 10 adds the step and 11 subtracts it. The step is 2 for word units and 1 for byte units.
- R3: Each unit is one read beat followed by one write beat. The write data equals the data returned by that unit's read. Neither valid is high together with the other. A valid beat keeps its address stable until accepted. Addresses advance only after the write handshake.
- R4: For word units, bit 0 of `rd_addr` and `wr_addr` is driven as 0, while the address held inside keeps its odd value and steps by 2.
- R5: Normal mode (00) moves exactly `cfg_count` units, then drops busy and raises `done`. A start with a count of 0 raises `done` without any bus beat.
- R6: Repeat mode (01) restores the area-side address to its loaded value after every `len` units, while the other side keeps stepping. The transfer continues until `stop`.
- R7: Block mode (10) moves `len` units per start pulse, then restores the area-side address and decrements the block count. Between blocks it stays busy with no bus beat until the next start. When the block count reaches zero it raises `done`.
- R8: Area side bit 1 makes the source the repeat or block area, and 0 makes the destination that area.
- R9: A start with transfer mode 11 issues no bus beat, leaves busy low and sets `err`.
- R10: `stop` while busy lets the unit in flight finish its write, then ends the transfer with `done`. `stop` during the between-blocks wait ends it at once.
- R11: `cfg_load` while busy is ignored. The running transfer keeps its mode, addresses and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load descriptor fields (idle only) |
| cfg_mode | input | 8 | Mode byte |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Unit count (normal) or block count (block) |
| cfg_len | input | LW | Area length in units for repeat/block; 0 means 256 |
| start | input | 1 | Start pulse; also starts the next block |
| stop | input | 1 | Stop request |
| busy | output | 1 | Transfer active or waiting for next block |
| done | output | 1 | Transfer finished (sticky until load or start) |
| err | output | 1 | Prohibited mode was started (sticky until load) |
| rd_valid | output | 1 | Read beat request |
| rd_ready | input | 1 | Read beat accepted, data present |
| rd_addr | output | AW | Read address |
| rd_word | output | 1 | Read is a word |
| rd_data | input | DW | Read data |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Write address |
| wr_word | output | 1 | Write is a word |
| wr_data | output | DW | Write data |

## Verification
The assertions watch the bus protocol on every cycle. Read and write valid are never high together. A stalled beat keeps its address. A write starts only after an accepted read. They also check that an error or done state never coexists with busy, and that a fixed side holds its address across a unit. The bench scenarios show the address sequences for each stepping mode and unit size. They also cover the wrap points of repeat and block areas, the count-zero and prohibited-mode starts, and stop timing. Finally, they show that a load during a transfer leaves it untouched.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_BAD    = 2'b11
  } xmode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_HOLD
  } state_e;

  // field positions follow the mode byte (MSB first)
  typedef struct packed {
    logic [1:0] src_am;
    logic [1:0] dst_am;
    xmode_e     xmode;
    logic       area_src;
    logic       word;
  } mode_t;

endpackage

// File: rtl/xseq_step.sv
module xseq_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    am,
  input  logic          word,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] stepv;

  always_comb begin
    stepv = word ? AW'(2) : AW'(1);
    if (!am[1])       nxt = addr;
    else if (!am[0])  nxt = addr + stepv;
    else              nxt = addr - stepv;
  end
endmodule

// File: rtl/xseq_side.sv
module xseq_side #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  input  logic          restore,
  input  logic [1:0]    am,
  input  logic          word,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] cur_q, base_q, stepped;

  xseq_step #(.AW(AW)) u_step (
    .addr (cur_q),
    .am   (am),
    .word (word),
    .nxt  (stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
    end else if (load) begin
      cur_q  <= load_addr;
      base_q <= load_addr;
    end else if (adv) begin
      cur_q  <= restore ? base_q : stepped;
    end
  end

  assign cur = cur_q;

  // fixed stepping keeps the address across a completed unit
  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restore && !am[1] && !load) |=> (cur_q == $past(cur_q)));

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [7:0]    cfg_mode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [LW-1:0] cfg_len,
  input  logic          start,
  input  logic          stop,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic          rd_word,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic          wr_word,
  output logic [DW-1:0] wr_data
);
  localparam int NSIDE = 2;
  localparam int SRC   = 0;
  localparam int DST   = 1;

  state_e        state_q;
  mode_t         mode_q;
  logic [CW-1:0] cnt_q, cnt_dec;
  logic [LW-1:0] len_q, rcnt_q, rcnt_dec;
  logic [DW-1:0] data_q;
  logic          done_q, err_q, stop_q;

  logic          load_ok, wr_hs, unit_wrap, area_evt, stop_any, fin, hold;
  logic [AW-1:0] side_addr [NSIDE];
  logic [AW-1:0] side_init [NSIDE];
  logic [1:0]    side_am   [NSIDE];
  logic          side_rst  [NSIDE];

  assign load_ok   = cfg_load && (state_q == ST_IDLE);
  assign wr_hs     = (state_q == ST_WR) && wr_ready;
  assign cnt_dec   = cnt_q - CW'(1);
  assign rcnt_dec  = rcnt_q - LW'(1);
  assign unit_wrap = (rcnt_dec == '0);
  assign area_evt  = wr_hs && unit_wrap &&
                     (mode_q.xmode == XM_REPEAT || mode_q.xmode == XM_BLOCK);
  assign stop_any  = stop_q || stop;

  assign side_init[SRC] = cfg_src;
  assign side_init[DST] = cfg_dst;
  assign side_am[SRC]   = mode_q.src_am;
  assign side_am[DST]   = mode_q.dst_am;
  assign side_rst[SRC]  = area_evt && mode_q.area_src;
  assign side_rst[DST]  = area_evt && !mode_q.area_src;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    xseq_side #(.AW(AW)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_ok),
      .load_addr (side_init[g]),
      .adv       (wr_hs),
      .restore   (side_rst[g]),
      .am        (side_am[g]),
      .word      (mode_q.word),
      .cur       (side_addr[g])
    );
  end

  // end-of-unit decision
  always_comb begin
    fin  = stop_any;
    hold = 1'b0;
    unique case (mode_q.xmode)
      XM_NORMAL: fin = stop_any || (cnt_dec == '0);
      XM_BLOCK: begin
        fin  = stop_any || (unit_wrap && cnt_dec == '0);
        hold = unit_wrap && !fin;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      rcnt_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          stop_q <= 1'b0;
          if (load_ok) begin
            mode_q <= mode_t'(cfg_mode);
            cnt_q  <= cfg_count;
            len_q  <= cfg_len;
            rcnt_q <= cfg_len;
            done_q <= 1'b0;
            err_q  <= 1'b0;
          end else if (start) begin
            if (mode_q.xmode == XM_BAD) begin
              err_q <= 1'b1;
            end else if (mode_q.xmode != XM_REPEAT && cnt_q == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q  <= 1'b0;
              rcnt_q  <= len_q;
              state_q <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (stop) stop_q <= 1'b1;
          if (rd_ready) begin
            data_q  <= rd_data;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (stop) stop_q <= 1'b1;
          if (wr_ready) begin
            if (mode_q.xmode != XM_NORMAL)
              rcnt_q <= unit_wrap ? len_q : rcnt_dec;
            if (mode_q.xmode == XM_NORMAL ||
                (mode_q.xmode == XM_BLOCK && unit_wrap))
              cnt_q <= cnt_dec;
            if (fin) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (hold) begin
              state_q <= ST_HOLD;
            end else begin
              state_q <= ST_RD;
            end
          end
        end
        ST_HOLD: begin
          if (stop) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (start) begin
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign rd_valid = (state_q == ST_RD);
  assign wr_valid = (state_q == ST_WR);
  assign rd_word  = mode_q.word;
  assign wr_word  = mode_q.word;
  assign wr_data  = data_q;
  assign rd_addr  = {side_addr[SRC][AW-1:1], side_addr[SRC][0] & ~mode_q.word};
  assign wr_addr  = {side_addr[DST][AW-1:1], side_addr[DST][0] & ~mode_q.word};

  assert_one_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(rd_valid && rd_ready));
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/sim_xfer_seq.sv
module sim_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_mode = '0;
  logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_count = '0;
  logic [7:0]  cfg_len = '0;
  logic        start = 1'b0, stop = 1'b0;
  logic        busy, done, err;
  logic        rd_valid, rd_word, wr_valid, wr_word;
  logic        rd_ready = 1'b1, wr_ready = 1'b1;
  logic [15:0] rd_addr, wr_addr, rd_data, wr_data;

  int checks = 0, failures = 0;
  int nr = 0, nw = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;
  logic [15:0] rlog [0:15];
  logic [15:0] wlog [0:15];
  logic [15:0] dlog [0:15];

  xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_len(cfg_len),
    .start(start), .stop(stop), .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_word(rd_word),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_word(wr_word), .wr_data(wr_data)
  );

  always #4 clk = ~clk;

  assign rd_data = rd_addr ^ 16'hA5C3;

  always @(negedge clk) begin
    rd_ready <= stall ? ~rd_ready : 1'b1;
    wr_ready <= stall ? ~wr_ready : 1'b1;
  end

  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin
      if (nr < 16) rlog[nr] <= rd_addr;
      nr <= nr + 1;
    end
    if (wr_valid && wr_ready) begin
      if (nw < 16) begin
        wlog[nw] <= wr_addr;
        dlog[nw] <= wr_data;
      end
      nw <= nw + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] m, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] c, input logic [7:0] l);
    @(negedge clk);
    cfg_mode = m; cfg_src = s; cfg_dst = d; cfg_count = c; cfg_len = l;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    nr = 0; nw = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " transfer ends"}, busy, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset err", err, 0);
    chk("R3 reset rd_valid", rd_valid, 0);
    chk("R3 reset wr_valid", wr_valid, 0);
  endtask

  // byte units, source up, destination down, with stalls
  task automatic t_normal_byte();
    logic [15:0] es [3] = '{16'h0100, 16'h0101, 16'h0102};
    logic [15:0] ed [3] = '{16'h0200, 16'h01FF, 16'h01FE};
    clear_logs();
    stall = 1'b1;
    do_load(8'hB0, 16'h0100, 16'h0200, 16'd3, 8'd0);
    chk("R1 load clears done", done, 0);
    pulse_start();
    wait_idle("R5");
    stall = 1'b0;
    chk("R5 unit count", nw, 3);
    chk("R5 done raised", done, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R2 source increment", rlog[i], es[i]);
      chk("R2 destination decrement", wlog[i], ed[i]);
      chk("R3 write data from read", dlog[i], es[i] ^ 16'hA5C3);
    end
  endtask

  // word units, source down from odd address, destination fixed
  task automatic t_normal_word();
    logic [15:0] es [3] = '{16'h0300, 16'h02FE, 16'h02FC};
    clear_logs();
    do_load(8'hD1, 16'h0301, 16'h0401, 16'd3, 8'd0);
    pulse_start();
    wait_idle("R5");
    chk("R5 word unit count", nw, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 aligned source word step 2", rlog[i], es[i]);
      chk("R2 R4 fixed destination aligned", wlog[i], 16'h0400);
    end
  endtask

  task automatic t_count_zero();
    clear_logs();
    do_load(8'hA0, 16'h0010, 16'h0020, 16'd0, 8'd0);
    pulse_start();
    chk("R5 zero count done", done, 1);
    chk("R5 zero count idle", busy, 0);
    repeat (4) @(negedge clk);
    chk("R5 zero count no beat", nr, 0);
  endtask

  task automatic t_bad_mode();
    clear_logs();
    do_load(8'hAC, 16'h0010, 16'h0020, 16'd4, 8'd2);
    pulse_start();
    chk("R9 err set", err, 1);
    chk("R9 stays idle", busy, 0);
    repeat (4) @(negedge clk);
    chk("R9 no bus beat", nr, 0);
    do_load(8'hA0, 16'h0010, 16'h0020, 16'd1, 8'd0);
    chk("R1 load clears err", err, 0);
  endtask

  // repeat, destination is area, len 2, stop during unit 5
  task automatic t_repeat();
    logic [15:0] ed [5] = '{16'h0020, 16'h0021, 16'h0020, 16'h0021, 16'h0020};
    clear_logs();
    do_load(8'hA4, 16'h0010, 16'h0020, 16'd0, 8'd2);
    pulse_start();
    while (nw < 4) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    wait_idle("R10");
    chk("R10 stop finishes unit in flight", nw, 5);
    chk("R10 done after stop", done, 1);
    for (int i = 0; i < 5; i++) begin
      chk("R6 other side keeps stepping", rlog[i], 16'h0010 + 16'(i));
      chk("R6 R8 destination area wraps", wlog[i], ed[i]);
    end
  endtask

  // block, source is area, len 3, two blocks, load while waiting
  task automatic t_block();
    clear_logs();
    do_load(8'hAA, 16'h0050, 16'h0060, 16'd2, 8'd3);
    pulse_start();
    while (nw < 3) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 waits busy between blocks", busy, 1);
    chk("R7 no beat between blocks", rd_valid, 0);
    chk("R7 first block size", nr, 3);
    do_load(8'hA0, 16'h0700, 16'h0800, 16'd0, 8'd1);
    chk("R11 load while busy ignored busy", busy, 1);
    pulse_start();
    wait_idle("R7");
    chk("R7 done after block count", done, 1);
    chk("R7 R11 total units", nw, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R7 R8 source area restored", rlog[i], 16'h0050 + 16'(i % 3));
      chk("R7 R11 destination continues", wlog[i], 16'h0060 + 16'(i));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal_byte();
    t_normal_word();
    t_count_zero();
    t_bad_mode();
    t_repeat();
    t_block();
    summary();
  end
endmodule